// File: doc/BRIEF.md
# Memory Error Logging Register File

This block sits beside a memory controller's ECC datapath and records error events so software can find them. Two event inputs, one for corrected (single-bit) errors and one for uncorrectable (multi-bit) errors, arrive as one-cycle pulses. Each pulse comes with the address of the failing access and the number of the memory row (one of eight) that was hit. The block keeps the first event of each class. It then ignores later events of that class until software acknowledges the event by writing a one to the flag.

Software reaches three registers through a small synchronous register port. The port has a 2-bit select, a write strobe, 32-bit write data and a combinational 32-bit read path. The pointer register holds the 4 KB page of the logged error. The status register holds the two class flags and the row captured for each class. The command register holds one enable per class. A level system-error output is raised whenever a logged flag has its enable set, and it stays high until the flag is cleared or the enable is removed.

Top module: `mem_err_log`

## Requirements
- R1: After reset all three registers read zero and `serr_o` is low.
- R2: Select 0 is the pointer register. Bits 31:12 hold bits 31:12 of the captured error address. Bits 11:2 read zero. Bit 0 is the single-bit flag and bit 1 is the multi-bit flag.
- R3: While a class flag is set and is not being cleared, further pulses of that class change neither that flag nor its row. A single-bit pulse in that state also leaves the address unchanged.
- R4: Select 1 is the status register. Bit 0 is the single-bit flag, bits 3:1 hold its captured row, bit 4 is the multi-bit flag and bits 7:5 hold its captured row. Bits 31:8 read zero. The flags are the same ones seen at select 0.
- R5: Writing one clears a flag. At select 0, bit 0 clears the single-bit flag and bit 1 clears the multi-bit flag. At select 1, bit 0 clears the single-bit flag and bit 4 clears the multi-bit flag. Zero bits and all other bits have no effect, and the rows and the address are read-only.
- R6: When a pulse and a clear of the same class fall in the same cycle, the flag stays set and the new row and address are captured.
- R7: A multi-bit capture always writes the address, including when a single-bit error is already logged. A single-bit capture writes the address only if no multi-bit error stays logged after that cycle.
- R8: Select 2 is the command register. Bits 1:0 are read/write and the other bits read zero. Select 3 reads zero and ignores writes.
- R9: `serr_o` is high exactly when (single-bit flag AND command bit 0) OR (multi-bit flag AND command bit 1). It is driven from register state, so it changes right after the clock edge that changes a flag or an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_in | input | 1 | Single-bit error pulse |
| mbe_in | input | 1 | Multi-bit error pulse |
| err_addr | input | 32 | Address of the failing access |
| err_row | input | 3 | Row of the failing access |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| serr_o | output | 1 | System error, level |

## Verification
Nearly all state in this block is visible at the ports. The flags, rows, page address and enables all appear on `reg_rdata` one edge after they are updated. A flag that is lost or latched twice therefore shows up on the very next read of the pointer or status register. It also appears on `serr_o` in the same cycle, once the class is enabled. The bench reads all three registers after every edge and compares them with a behavioural model. A wrong capture, a missed clear or a wrong address-priority decision is therefore reported within one cycle of the event that caused it.

// File: rtl/mem_err_log.sv
module mem_err_log #(
  parameter int AW   = 32,
  parameter int ROWW = 3,
  parameter int PLSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sbe_in,
  input  logic          mbe_in,
  input  logic [AW-1:0] err_addr,
  input  logic [ROWW-1:0] err_row,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          serr_o
);
  localparam int PW = AW - PLSB;

  logic            sbe_f, mbe_f;
  logic [ROWW-1:0] sbe_row, mbe_row;
  logic [PW-1:0]   page;
  logic [1:0]      cmd;

  wire wr_ptr = reg_we && reg_sel == 2'd0;
  wire wr_sts = reg_we && reg_sel == 2'd1;
  wire clr_s  = (wr_ptr && reg_wdata[0]) || (wr_sts && reg_wdata[0]);
  wire clr_m  = (wr_ptr && reg_wdata[1]) || (wr_sts && reg_wdata[2*ROWW-2]);
  wire cap_s  = sbe_in && (!sbe_f || clr_s);
  wire cap_m  = mbe_in && (!mbe_f || clr_m);
  wire keep_m = mbe_f && !clr_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_f   <= 1'b0;
      mbe_f   <= 1'b0;
      sbe_row <= '0;
      mbe_row <= '0;
      page    <= '0;
      cmd     <= '0;
    end else begin
      if (cap_s) begin
        sbe_f   <= 1'b1;
        sbe_row <= err_row;
      end else if (clr_s) begin
        sbe_f <= 1'b0;
      end
      if (cap_m) begin
        mbe_f   <= 1'b1;
        mbe_row <= err_row;
      end else if (clr_m) begin
        mbe_f <= 1'b0;
      end
      if (cap_m || (cap_s && !keep_m))
        page <= err_addr[AW-1:PLSB];
      if (reg_we && reg_sel == 2'd2)
        cmd <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {page, {(PLSB-2){1'b0}}, mbe_f, sbe_f};
      2'd1:    reg_rdata = {{(AW-2*ROWW-2){1'b0}}, mbe_row, mbe_f, sbe_row, sbe_f};
      2'd2:    reg_rdata = {{(AW-2){1'b0}}, cmd};
      default: reg_rdata = '0;
    endcase
  end

  assign serr_o = (sbe_f && cmd[0]) || (mbe_f && cmd[1]);
endmodule

// File: rtl/mem_err_log_chk.sv
module mem_err_log_chk #(
  parameter int ROWW = 3,
  parameter int PW   = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sbe_in,
  input logic            mbe_in,
  input logic [1:0]      reg_sel,
  input logic            reg_we,
  input logic            serr_o,
  input logic            sbe_f,
  input logic            mbe_f,
  input logic [ROWW-1:0] sbe_row,
  input logic [ROWW-1:0] mbe_row,
  input logic [PW-1:0]   page,
  input logic [1:0]      cmd
);
  assert_sbe_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_f && !sbe_in) |=> $stable(sbe_row));
  assert_mbe_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbe_f && !mbe_in) |=> $stable(mbe_row));
  assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sbe_in && !mbe_in) |=> $stable(page));
  assert_sbe_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sbe_f) |-> $past(sbe_in));
  assert_sbe_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_in |=> sbe_f);
  assert_mbe_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mbe_in |=> mbe_f);
  assert_serr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sbe_f && !mbe_f) |-> !serr_o);
  assert_serr_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b00) |-> !serr_o);
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == 2'd2) |=> $stable(cmd));
endmodule

bind mem_err_log mem_err_log_chk #(.ROWW(ROWW), .PW(AW-PLSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .sbe_in(sbe_in), .mbe_in(mbe_in),
  .reg_sel(reg_sel), .reg_we(reg_we), .serr_o(serr_o),
  .sbe_f(sbe_f), .mbe_f(mbe_f), .sbe_row(sbe_row), .mbe_row(mbe_row),
  .page(page), .cmd(cmd)
);

// File: tb/mem_err_log_tb.sv
module mem_err_log_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        sbe_in = 0, mbe_in = 0;
  logic [31:0] err_addr = 0;
  logic [2:0]  err_row = 0;
  logic [1:0]  reg_sel = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        serr_o;

  mem_err_log u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;

  bit       m_s, m_m;
  bit [2:0] m_sr, m_mr;
  bit [19:0] m_pg;
  bit [1:0] m_cmd;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    reg_sel = 2'd0; #1 check({tag, " ptr"}, reg_rdata, {m_pg, 10'b0, m_m, m_s});
    reg_sel = 2'd1; #1 check({tag, " sts"}, reg_rdata, {24'b0, m_mr, m_m, m_sr, m_s});
    reg_sel = 2'd2; #1 check({tag, " cmd"}, reg_rdata, {30'b0, m_cmd});
    reg_sel = 2'd3; #1 check({tag, " sel3"}, reg_rdata, 32'b0);
    check({tag, " serr"}, {31'b0, serr_o}, {31'b0, (m_s & m_cmd[0]) | (m_m & m_cmd[1])});
  endtask

  task automatic cyc(string tag, bit s, bit m, bit [31:0] a, bit [2:0] r,
                     bit we, bit [1:0] sel, bit [31:0] wd);
    bit cs, cm, ks, km, keep;
    @(negedge clk);
    sbe_in = s; mbe_in = m; err_addr = a; err_row = r;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    cs = we && ((sel == 0 && wd[0]) || (sel == 1 && wd[0]));
    cm = we && ((sel == 0 && wd[1]) || (sel == 1 && wd[4]));
    ks = s && (!m_s || cs);
    km = m && (!m_m || cm);
    keep = m_m && !cm;
    @(posedge clk); #1;
    if (ks) begin m_s = 1; m_sr = r; end else if (cs) m_s = 0;
    if (km) begin m_m = 1; m_mr = r; end else if (cm) m_m = 0;
    if (km || (ks && !keep)) m_pg = a[31:12];
    if (we && sel == 2) m_cmd = wd[1:0];
    sbe_in = 0; mbe_in = 0; reg_we = 0;
    compare_all(tag);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare_all("R1 reset");
    @(negedge clk); rst_n = 1;
    cyc("R1 idle", 0,0,0,0, 0,0,0);
    // R2 R4 first single-bit capture
    cyc("R2 sbe cap", 1,0,32'hABCD_E123,3'd5, 0,0,0);
    // R3 second sbe ignored
    cyc("R3 sbe held", 1,0,32'h1111_1FFF,3'd2, 0,0,0);
    // R9 enable single-bit reporting
    cyc("R9 en sbe", 0,0,0,0, 1,2,32'hFFFF_FFF1);
    // R5 write zeros / unrelated bits, no clear
    cyc("R5 no clr", 0,0,0,0, 1,0,32'hFFFF_F000);
    cyc("R5 no clr sts", 0,0,0,0, 1,1,32'h0000_00EE);
    // R7 mbe overwrites page while sbe logged
    cyc("R7 mbe over", 0,1,32'h7654_3000,3'd7, 0,0,0);
    // R7 R3 sbe while mbe logged (after sbe clear) no page write
    cyc("R5 clr sbe ptr", 0,0,0,0, 1,0,32'h1);
    cyc("R7 sbe no addr", 1,0,32'h2222_2000,3'd1, 0,0,0);
    cyc("R3 mbe held", 0,1,32'h3333_3000,3'd3, 0,0,0);
    // R9 mbe enable only
    cyc("R9 en mbe", 0,0,0,0, 1,2,32'h2);
    cyc("R5 clr mbe sts", 0,0,0,0, 1,1,32'h10);
    // R6 clear and new error same cycle
    cyc("R6 sbe win", 1,0,32'h4444_4000,3'd4, 1,1,32'h1);
    cyc("R6 mbe win", 0,1,32'h5555_5000,3'd6, 1,0,32'h2);
    cyc("R6 both win", 1,1,32'h6666_6000,3'd2, 1,0,32'h3);
    // R8 select 3 ignored, cmd upper bits read zero
    cyc("R8 sel3", 0,0,0,0, 1,3,32'hFFFF_FFFF);
    cyc("R8 cmd both", 0,0,0,0, 1,2,32'h3);
    cyc("R5 clr all", 0,0,0,0, 1,0,32'h3);
    cyc("R7 sbe only", 1,0,32'h8888_8000,3'd0, 0,0,0);
    cyc("R7 both fresh", 1,1,32'h9999_9000,3'd5, 1,1,32'h11);
    for (int i = 0; i < 40; i++)
      cyc("R3 mix", i[0], i[2] & i[1], {i[7:0], 24'h5A5000}, i[2:0],
          i[3], i[5:4], {27'b0, i[4:0]});
    cyc("R8 cmd off", 0,0,0,0, 1,2,0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule